// File: doc/BRIEF.md
# Clock Page Reclaim Engine

This block tracks a referenced bit and a modified bit for each physical frame of a fixed pool, and reclaims frames with a two-pointer clock sweep. Every memory access reports its frame number and whether it was a write. While reclaim is requested, a front hand moves one frame per cycle and clears the referenced bit of each frame it passes. A rear hand follows a fixed number of frames behind. It looks at each frame it reaches and sends it to one of three places: an internal FIFO of free frames, a write-back request (if the frame is modified), or nowhere.

A frame that has been placed on the free list, or that is waiting for its write-back, is passed over by the rear hand. The consumer takes free frames from the head of the FIFO with a pop strobe, which makes that frame ordinary again. The external copy engine reports the end of a write-back with a completion pulse. That pulse cleans the frame, so a later pass of the sweep can free it. When the FIFO is full, the sweep halts until space opens.

Top module: `clk_page_reclaim`

## Requirements
- R1: After reset the free list is empty (`free_valid`=0, `free_full`=0), `wb_valid`=0, and every frame is unreferenced and clean. The front hand is at frame 0 and the rear hand is at frame FRAMES-GAP.
- R2: A reference (`ref_valid`=1) sets the referenced bit of `ref_frame`. If `ref_write`=1, it also sets that frame's modified bit.
- R3: In each cycle the sweep is active, the front hand clears the referenced bit of its frame. Both hands then advance by one modulo FRAMES, and the rear hand always stays GAP frames behind the front hand.
- R4: The rear hand pushes a frame onto the free list when the frame is unreferenced, clean, not already listed and not pending write-back. Frames leave the list in push order, and `free_frame` shows the head frame whenever `free_valid`=1.
- R5: A modified frame that is otherwise eligible is not freed. It is marked pending, and in the next cycle `wb_valid`=1 for one cycle with `wb_frame` set to that frame.
- R6: A `wb_done` pulse clears the modified bit and the pending mark of `wb_done_frame`. A later pass can then free the frame. A write reference in the same cycle keeps the frame modified.
- R7: The rear hand skips frames that are listed or pending. A frame popped from the list becomes eligible again.
- R8: A reference wins over a clear by the front hand in the same cycle, so the referenced bit stays set. A reference to the rear hand's frame in the same cycle also keeps that frame from being reclaimed.
- R9: `free_full`=1 when the list holds FREE_DEPTH frames. While it is full, the sweep stalls: no hand moves and no bit changes. A pop (`free_pop` with `free_valid`=1) removes the head.
- R10: The hands move only while `reclaim_req`=1. When `reclaim_req`=0, no frame is freed or sent for write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Reference notification strobe |
| ref_frame | input | FW | Frame being referenced |
| ref_write | input | 1 | Reference was a write |
| reclaim_req | input | 1 | Run the sweep while high |
| wb_done | input | 1 | Write-back completion pulse |
| wb_done_frame | input | FW | Frame whose write-back finished |
| free_pop | input | 1 | Take the head of the free list |
| free_valid | output | 1 | Free list is not empty |
| free_frame | output | FW | Frame at the head of the free list |
| free_full | output | 1 | Free list holds FREE_DEPTH frames |
| wb_valid | output | 1 | Write-back request pulse |
| wb_frame | output | FW | Frame to write back |

## Verification
The assertions assume that `wb_done` is raised only for a frame with a write-back outstanding, and that frame numbers are below FRAMES. The stimulus picks each completion from the pending set of a cycle-level model kept in the bench, and it draws frame numbers only from the frame range. Pops are issued freely, because the block ignores a pop while the list is empty. Two targeted phases aim references at the front hand and then at the rear hand in the very cycle the hand reaches the frame, which exercises the same-cycle precedence rules.

// File: rtl/clk_reclaim_pkg.sv
package clk_reclaim_pkg;
  // Decision taken by the rear hand for the frame under it
  typedef enum logic [1:0] {
    ACT_SKIP = 2'd0,
    ACT_FREE = 2'd1,
    ACT_WB   = 2'd2
  } trail_act_e;
endpackage

// File: rtl/clk_frame_state.sv
module clk_frame_state #(
  parameter int FRAMES = 16,
  parameter int FW     = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_valid,
  input  logic [FW-1:0]     ref_frame,
  input  logic              ref_write,
  input  logic              wb_done,
  input  logic [FW-1:0]     wb_done_frame,
  input  logic              pop_valid,
  input  logic [FW-1:0]     pop_frame,
  input  logic              clr_valid,
  input  logic [FW-1:0]     clr_frame,
  input  logic              mark_free,
  input  logic              mark_wb,
  input  logic [FW-1:0]     mark_frame,
  output logic [FRAMES-1:0] used_q,
  output logic [FRAMES-1:0] dirty_q,
  output logic [FRAMES-1:0] onfree_q,
  output logic [FRAMES-1:0] wbpend_q
);

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    logic hit_ref, hit_clr, hit_wbd, hit_pop, hit_mark;
    assign hit_ref  = ref_valid && (ref_frame     == FW'(f));
    assign hit_clr  = clr_valid && (clr_frame     == FW'(f));
    assign hit_wbd  = wb_done   && (wb_done_frame == FW'(f));
    assign hit_pop  = pop_valid && (pop_frame     == FW'(f));
    assign hit_mark = (mark_frame == FW'(f));

    always_ff @(posedge clk) begin
      if (rst) begin
        used_q[f]   <= 1'b0;
        dirty_q[f]  <= 1'b0;
        onfree_q[f] <= 1'b0;
        wbpend_q[f] <= 1'b0;
      end else begin
        if (hit_ref)      used_q[f] <= 1'b1;
        else if (hit_clr) used_q[f] <= 1'b0;

        if (hit_ref && ref_write) dirty_q[f] <= 1'b1;
        else if (hit_wbd)         dirty_q[f] <= 1'b0;

        if (hit_mark && mark_wb) wbpend_q[f] <= 1'b1;
        else if (hit_wbd)        wbpend_q[f] <= 1'b0;

        if (hit_mark && mark_free) onfree_q[f] <= 1'b1;
        else if (hit_pop)          onfree_q[f] <= 1'b0;
      end
    end
  end

  // R8
  ref_wins_chk: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> used_q[$past(ref_frame)]);

  // R6
  wb_done_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_done && !(ref_valid && ref_write && ref_frame == wb_done_frame))
      |=> !dirty_q[$past(wb_done_frame)] && !wbpend_q[$past(wb_done_frame)]);

  // R7
  free_pend_excl_chk: assert property (@(posedge clk) disable iff (rst)
    (onfree_q & wbpend_q) == '0);

endmodule

// File: rtl/clk_sweep.sv
module clk_sweep
  import clk_reclaim_pkg::*;
#(
  parameter int FRAMES = 16,
  parameter int GAP    = 4,
  parameter int FW     = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reclaim_req,
  input  logic              full,
  input  logic              ref_valid,
  input  logic [FW-1:0]     ref_frame,
  input  logic [FRAMES-1:0] used_q,
  input  logic [FRAMES-1:0] dirty_q,
  input  logic [FRAMES-1:0] onfree_q,
  input  logic [FRAMES-1:0] wbpend_q,
  output logic              go,
  output logic [FW-1:0]     lead,
  output logic [FW-1:0]     trail,
  output trail_act_e        act,
  output logic              wb_valid,
  output logic [FW-1:0]     wb_frame
);

  localparam logic [FW-1:0] LAST      = FW'(FRAMES - 1);
  localparam logic [FW-1:0] TRAIL_RST = FW'(FRAMES - GAP);

  logic ref_trail;

  function automatic logic [FW-1:0] wrap_inc(input logic [FW-1:0] p);
    return (p == LAST) ? '0 : p + FW'(1);
  endfunction

  always_comb begin
    go        = reclaim_req && !full;
    ref_trail = ref_valid && (ref_frame == trail);
    act       = ACT_SKIP;
    if (go && !onfree_q[trail] && !wbpend_q[trail] && !used_q[trail] && !ref_trail)
      act = dirty_q[trail] ? ACT_WB : ACT_FREE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lead     <= '0;
      trail    <= TRAIL_RST;
      wb_valid <= 1'b0;
      wb_frame <= '0;
    end else begin
      wb_valid <= (act == ACT_WB);
      if (act == ACT_WB) wb_frame <= trail;
      if (go) begin
        lead  <= wrap_inc(lead);
        trail <= wrap_inc(trail);
      end
    end
  end

  // R3
  ptr_gap_chk: assert property (@(posedge clk) disable iff (rst)
    int'(trail) == ((int'(lead) + FRAMES - GAP) % FRAMES));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reclaim_req |=> $stable(lead) && !wb_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (reclaim_req && full) |=> $stable(lead) && $stable(trail));

endmodule

// File: rtl/clk_free_fifo.sv
module clk_free_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          not_empty,
  output logic          full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] ALAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_pop;

  assign not_empty = (count != '0);
  assign full      = (count == CW'(DEPTH));
  assign do_pop    = pop && not_empty;
  assign head      = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= (wr_ptr == ALAST) ? '0 : wr_ptr + AW'(1);
      if (do_pop) rd_ptr <= (rd_ptr == ALAST) ? '0 : rd_ptr + AW'(1);
      if (push && !do_pop)      count <= count + CW'(1);
      else if (!push && do_pop) count <= count - CW'(1);
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> (count < CW'(DEPTH)));

  // R4
  push_visible_chk: assert property (@(posedge clk) disable iff (rst)
    push |=> not_empty);

endmodule

// File: rtl/clk_page_reclaim.sv
module clk_page_reclaim
  import clk_reclaim_pkg::*;
#(
  parameter int FRAMES     = 16,
  parameter int GAP        = 4,
  parameter int FREE_DEPTH = 8,
  localparam int FW        = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_valid,
  input  logic [FW-1:0] ref_frame,
  input  logic          ref_write,
  input  logic          reclaim_req,
  input  logic          wb_done,
  input  logic [FW-1:0] wb_done_frame,
  input  logic          free_pop,
  output logic          free_valid,
  output logic [FW-1:0] free_frame,
  output logic          free_full,
  output logic          wb_valid,
  output logic [FW-1:0] wb_frame
);

  logic [FRAMES-1:0] used_q, dirty_q, onfree_q, wbpend_q;
  logic              go, pop_valid;
  logic [FW-1:0]     lead, trail;
  trail_act_e        act;

  assign pop_valid = free_pop && free_valid;

  clk_frame_state #(.FRAMES(FRAMES), .FW(FW)) u_state (
    .clk(clk), .rst(rst),
    .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
    .wb_done(wb_done), .wb_done_frame(wb_done_frame),
    .pop_valid(pop_valid), .pop_frame(free_frame),
    .clr_valid(go), .clr_frame(lead),
    .mark_free(act == ACT_FREE), .mark_wb(act == ACT_WB), .mark_frame(trail),
    .used_q(used_q), .dirty_q(dirty_q), .onfree_q(onfree_q), .wbpend_q(wbpend_q)
  );

  clk_sweep #(.FRAMES(FRAMES), .GAP(GAP), .FW(FW)) u_sweep (
    .clk(clk), .rst(rst),
    .reclaim_req(reclaim_req), .full(free_full),
    .ref_valid(ref_valid), .ref_frame(ref_frame),
    .used_q(used_q), .dirty_q(dirty_q), .onfree_q(onfree_q), .wbpend_q(wbpend_q),
    .go(go), .lead(lead), .trail(trail), .act(act),
    .wb_valid(wb_valid), .wb_frame(wb_frame)
  );

  clk_free_fifo #(.DEPTH(FREE_DEPTH), .DW(FW)) u_fifo (
    .clk(clk), .rst(rst),
    .push(act == ACT_FREE), .push_data(trail),
    .pop(free_pop),
    .head(free_frame), .not_empty(free_valid), .full(free_full)
  );

  // R5
  wb_pending_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> wbpend_q[wb_frame]);

  // R4
  listed_head_chk: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> onfree_q[free_frame]);

endmodule

// File: tb/sim_clk_page_reclaim.sv
`timescale 1ns/1ps
module sim_clk_page_reclaim;
  localparam int N  = 8;
  localparam int G  = 2;
  localparam int D  = 4;
  localparam int FW = $clog2(N);

  logic clk = 1'b0, rst = 1'b1;
  logic ref_valid = 0, ref_write = 0, reclaim_req = 0, wb_done = 0, free_pop = 0;
  logic [FW-1:0] ref_frame = '0, wb_done_frame = '0;
  logic free_valid, free_full, wb_valid;
  logic [FW-1:0] free_frame, wb_frame;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  clk_page_reclaim #(.FRAMES(N), .GAP(G), .FREE_DEPTH(D)) u0 (
    .clk(clk), .rst(rst),
    .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
    .reclaim_req(reclaim_req), .wb_done(wb_done), .wb_done_frame(wb_done_frame),
    .free_pop(free_pop),
    .free_valid(free_valid), .free_frame(free_frame), .free_full(free_full),
    .wb_valid(wb_valid), .wb_frame(wb_frame)
  );

  // Cycle-level model built from the requirements
  bit [N-1:0] m_used, m_dirty, m_free, m_pend;
  int m_lead, m_trail, m_cnt;
  int m_q [D];
  bit m_wbv;
  int m_wbf;

  task automatic model_reset();
    m_used = '0; m_dirty = '0; m_free = '0; m_pend = '0;
    m_lead = 0; m_trail = N - G; m_cnt = 0; m_wbv = 0; m_wbf = 0;
  endtask

  task automatic model_step();
    bit [N-1:0] nu, nd, nf, np;
    bit go, pop, uef;
    int rf, wf;
    nu = m_used; nd = m_dirty; nf = m_free; np = m_pend;
    rf = int'(ref_frame); wf = int'(wb_done_frame);
    go  = reclaim_req && (m_cnt != D);
    pop = free_pop && (m_cnt != 0);
    m_wbv = 0;
    if (go && !(ref_valid && rf == m_lead)) nu[m_lead] = 0;
    if (ref_valid) begin
      nu[rf] = 1;
      if (ref_write) nd[rf] = 1;
    end
    if (wb_done) begin
      np[wf] = 0;
      if (!(ref_valid && ref_write && rf == wf)) nd[wf] = 0;
    end
    if (pop) begin
      nf[m_q[0]] = 0;
      for (int i = 0; i < D - 1; i++) m_q[i] = m_q[i+1];
      m_cnt--;
    end
    if (go) begin
      uef = m_used[m_trail] || (ref_valid && rf == m_trail);
      if (!m_free[m_trail] && !m_pend[m_trail] && !uef) begin
        if (m_dirty[m_trail]) begin
          np[m_trail] = 1; m_wbv = 1; m_wbf = m_trail;
        end else begin
          nf[m_trail] = 1; m_q[m_cnt] = m_trail; m_cnt++;
        end
      end
      m_lead  = (m_lead + 1) % N;
      m_trail = (m_trail + 1) % N;
    end
    m_used = nu; m_dirty = nd; m_free = nf; m_pend = np;
  endtask

  task automatic compare(input string tag);
    bit ok;
    ok = (free_valid == (m_cnt != 0)) && (free_full == (m_cnt == D)) &&
         (wb_valid == m_wbv) &&
         (!m_wbv || int'(wb_frame) == m_wbf) &&
         (m_cnt == 0 || int'(free_frame) == m_q[0]);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got fv=%0b ff=%0d full=%0b wbv=%0b wbf=%0d exp fv=%0b ff=%0d full=%0b wbv=%0b wbf=%0d",
               tag, free_valid, free_frame, free_full, wb_valid, wb_frame,
               m_cnt != 0, (m_cnt != 0) ? m_q[0] : 0, m_cnt == D, m_wbv, m_wbf);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(tag);
  endtask

  function automatic int pick_pending(input int start);
    for (int i = 0; i < N; i++)
      if (m_pend[(start + i) % N]) return (start + i) % N;
    return -1;
  endfunction

  task automatic rand_misc(input int pop_pct, input int wbd_pct);
    int p;
    free_pop = ($urandom % 100) < pop_pct;
    p = pick_pending($urandom % N);
    wb_done = (p >= 0) && (($urandom % 100) < wbd_pct);
    wb_done_frame = (p >= 0) ? FW'(p) : '0;
  endtask

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state at the ports
    compare("R1 reset");

    // R2 R10: references only, sweep idle, outputs stay quiet
    for (int c = 0; c < 40; c++) begin
      ref_valid = 1; ref_frame = FW'($urandom % N); ref_write = ($urandom % 3) == 0;
      cyc("R10 idle with R2 references");
    end
    ref_valid = 0; ref_write = 0;

    // R3 R4 R5 R9: sweep with no consumer fills the list and stalls
    reclaim_req = 1;
    for (int c = 0; c < 40; c++) cyc("R9 fill/stall with R4 R5");

    // R6 R7: consumer, completions and mixed references
    for (int c = 0; c < 600; c++) begin
      ref_valid = ($urandom % 2) == 1; ref_frame = FW'($urandom % N);
      ref_write = ($urandom % 4) == 0;
      reclaim_req = ($urandom % 8) != 0;
      rand_misc(40, 30);
      cyc("R6 R7 R3 mixed sweep");
    end

    // R8: references aimed at the front hand
    for (int c = 0; c < 60; c++) begin
      reclaim_req = 1; ref_valid = 1; ref_frame = FW'(m_lead); ref_write = 0;
      rand_misc(60, 50);
      cyc("R8 front-hand reference");
    end

    // R8: references aimed at the rear hand
    for (int c = 0; c < 60; c++) begin
      reclaim_req = 1; ref_valid = 1; ref_frame = FW'(m_trail); ref_write = c[0];
      rand_misc(60, 50);
      cyc("R8 rear-hand reference");
    end

    // R6 R5: drain write-backs and free everything
    ref_valid = 0;
    for (int c = 0; c < 120; c++) begin
      reclaim_req = 1;
      rand_misc(70, 80);
      cyc("R6 drain and refree");
    end

    // R9: pops on an empty list are ignored
    reclaim_req = 0; wb_done = 0;
    for (int c = 0; c < 12; c++) begin
      free_pop = 1;
      cyc("R9 pop to empty");
    end
    free_pop = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule